// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block supervises software through a free-running up-counter that software must restart at regular intervals. A restart (a "feed") is accepted only when two key bytes arrive in the correct order at the feed register. Four programmable power-of-two thresholds watch the count. Two of them are late limits: one sets an interrupt flag, and the other sets a reset flag and can request a system reset. The other two are early limits. When window mode is on, a feed that lands below an early limit counts as an error. It sets its own flag and, for the reset limit, can request a reset.

Software reaches the block through a simple word-addressed register port. The port holds a control word, the feed register, a clock-source select field and the read-only count. Event flags are sticky, and software clears each one by writing 1 to it. The interrupt output combines the two interrupt flags under an enable bit. The reset request is a one-cycle pulse. The counter width is a parameter (16 to 32 bits; 32 by default). A threshold code n selects a count of 2^(CNT_W-1-n).

Top module: `window_watchdog`

## Requirements
- R1: After reset the count reads 0, `irq` and `rst_req` are low, and the control word at byte offset 0x00 reads 0x1000_0000 (only the clock-ready status, bit 28, is set).
- R2: While control bit 8 is 1, the count rises by one per clock. Clearing bit 8 freezes the count at its current value.
- R3: A 4-bit code n selects the threshold 2^(CNT_W-1-n). The late-interrupt code is in control bits [3:0]. Its flag, bit 9, sets on the edge where the count becomes that threshold.
- R4: The late-reset code is in bits [7:4]. Its flag, bit 31, sets on the edge where the count becomes that threshold. If bit 11 is 1, `rst_req` is high for exactly one cycle from that edge. If bit 11 is 0, `rst_req` stays low.
- R5: Writing 0xA5 and then 0x5A to bits [7:0] at offset 0x04 restarts the count at 0.
- R6: Any feed-register write after 0xA5 other than 0x5A returns the key check to idle, including a second 0xA5. A 0x5A without a preceding 0xA5 is ignored, and in both cases the count keeps running.
- R7: With window mode on (bit 29), a completed feed while the count is below the early-interrupt threshold (code in bits [19:16]) sets flag bit 12.
- R8: With window mode on, a completed feed while the count is below the early-reset threshold (code in bits [23:20]) sets flag bit 30 and, if bit 11 is 1, pulses `rst_req` for one cycle.
- R9: With window mode off, early feeds set no flag and request no reset.
- R10: `irq` equals (bit 9 OR bit 12) AND the interrupt enable, bit 10.
- R11: Writing 1 to a flag bit of the control word clears that flag. Writing 0 leaves it unchanged.
- R12: A feed that completes on the edge where the count would reach a late threshold wins. The count restarts at 0 and the late flag does not set.
- R13: Offset 0x08 stores a 3-bit clock-source field in bits [2:0], with the upper bits reading 0. Writes to the count register at offset 0x0C are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt output |
| rst_req | output | 1 | One-cycle system-reset request |

## Verification
The collision that matters is a completed feed on the same edge where the counter steps onto the late-interrupt threshold. The bench provokes it by reading the count and timing the two key writes so that the 0x5A write lands while the count is exactly one below the threshold. The check passes when the count then reads 0 and flag bit 9 is still clear. The counter is then left to run to the threshold, which confirms that the flag does set once no feed is pending.

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        rst_req
);

  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_FEED = 2'd1;
  localparam logic [1:0] IDX_CSEL = 2'd2;
  localparam logic [1:0] IDX_CNT  = 2'd3;
  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;
  localparam logic [5:0] TOP_EXP = 6'(CNT_W - 1);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [3:0] code_li, code_lr, code_ei, code_er;
  logic       run_en, int_en, rst_en, win_en, rdy_ie;
  logic       f_li, f_lr, f_ei, f_er;
  logic [2:0] csel;
  logic [CNT_W-1:0] cnt;
  logic       key_armed;

  function automatic logic [CNT_W-1:0] pow_thr(input logic [3:0] code);
    return ONE << (TOP_EXP - {2'b00, code});
  endfunction

  logic wr_ctrl, wr_feed, wr_csel, feed_done;
  assign wr_ctrl   = wr_en && addr[3:2] == IDX_CTRL;
  assign wr_feed   = wr_en && addr[3:2] == IDX_FEED;
  assign wr_csel   = wr_en && addr[3:2] == IDX_CSEL;
  assign feed_done = wr_feed && key_armed && wdata[7:0] == KEY_SECOND;

  logic [CNT_W-1:0] cnt_inc, thr_li, thr_lr, thr_ei, thr_er;
  assign cnt_inc = cnt + ONE;
  assign thr_li  = pow_thr(code_li);
  assign thr_lr  = pow_thr(code_lr);
  assign thr_ei  = pow_thr(code_ei);
  assign thr_er  = pow_thr(code_er);

  logic hit_li, hit_lr, early_ei, early_er;
  assign hit_li   = run_en && !feed_done && cnt_inc == thr_li;
  assign hit_lr   = run_en && !feed_done && cnt_inc == thr_lr;
  assign early_ei = feed_done && win_en && cnt < thr_ei;
  assign early_er = feed_done && win_en && cnt < thr_er;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (feed_done) begin
      cnt <= '0;
    end else if (run_en) begin
      cnt <= cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_armed <= 1'b0;
    else if (wr_feed) key_armed <= !key_armed && wdata[7:0] == KEY_FIRST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_li <= '0; code_lr <= '0; code_ei <= '0; code_er <= '0;
      run_en  <= 1'b0; int_en <= 1'b0; rst_en <= 1'b0;
      win_en  <= 1'b0; rdy_ie <= 1'b0;
      csel    <= '0;
    end else begin
      if (wr_ctrl) begin
        code_li <= wdata[3:0];
        code_lr <= wdata[7:4];
        run_en  <= wdata[8];
        int_en  <= wdata[10];
        rst_en  <= wdata[11];
        code_ei <= wdata[19:16];
        code_er <= wdata[23:20];
        rdy_ie  <= wdata[27];
        win_en  <= wdata[29];
      end
      if (wr_csel) csel <= wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_li <= 1'b0; f_lr <= 1'b0; f_ei <= 1'b0; f_er <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      f_li <= (f_li & ~(wr_ctrl & wdata[9]))  | hit_li;
      f_ei <= (f_ei & ~(wr_ctrl & wdata[12])) | early_ei;
      f_er <= (f_er & ~(wr_ctrl & wdata[30])) | early_er;
      f_lr <= (f_lr & ~(wr_ctrl & wdata[31])) | hit_lr;
      rst_req <= rst_en && (hit_lr || early_er);
    end
  end

  assign irq = int_en & (f_li | f_ei);

  always_comb begin
    unique case (addr[3:2])
      IDX_CTRL: rdata = {f_lr, f_er, win_en, 1'b1, rdy_ie, 3'b000, code_er, code_ei,
                         3'b000, f_ei, rst_en, int_en, f_li, run_en, code_lr, code_li};
      IDX_FEED: rdata = '0;
      IDX_CSEL: rdata = {29'd0, csel};
      IDX_CNT:  rdata = 32'(cnt);
      default:  rdata = '0;
    endcase
  end

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && !feed_done |=> cnt == $past(cnt_inc));
  a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en && !feed_done |=> $stable(cnt));
  a_r5_feed_restart: assert property (@(posedge clk) disable iff (!rst_n)
    feed_done |=> cnt == '0);
  a_r3_late_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hit_li |=> f_li);
  a_r4_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_en |=> !rst_req);
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    f_lr && !(wr_ctrl && wdata[31]) |=> f_lr);
  a_r6_key_second_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    wr_feed && !key_armed |=> !$past(feed_done));

endmodule

// File: tb/window_watchdog_bench.sv
module window_watchdog_bench;
  localparam int CLK_P = 10;
  localparam int CW = 20;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, rst_req;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  window_watchdog #(.CNT_W(CW)) u_window_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .rst_req(rst_req));

  always #(CLK_P/2) clk = ~clk;

  localparam logic [3:0] A_CTRL = 4'h0, A_FEED = 4'h4, A_CSEL = 4'h8, A_CNT = 4'hC;
  localparam logic [31:0] RUN = 32'h100, LI = 32'h200, IEN = 32'h400, REN = 32'h800;
  localparam logic [31:0] EI = 32'h1000, WIN = 32'h2000_0000, ER = 32'h4000_0000, LR = 32'h8000_0000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic feed();
    wr(A_FEED, 32'hA5);
    wr(A_FEED, 32'h5A);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h1000_0000);
    rd(A_CNT, v);  check("R1 count", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 rst_req", {31'd0, rst_req}, 0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(A_CTRL, RUN);
    repeat (10) @(negedge clk);
    rd(A_CNT, v); check("R2 running", v, 10);
    wr(A_CTRL, 0);
    repeat (5) @(negedge clk);
    rd(A_CNT, v); check("R2 frozen", v, 11);
    feed();
  endtask

  task automatic t_late_int();
    logic [31:0] v;
    wr(A_CTRL, RUN | IEN | 32'hF);
    repeat (15) @(negedge clk);
    rd(A_CTRL, v); check("R3 before threshold", {31'd0, v[9]}, 0);
    check("R10 irq low", {31'd0, irq}, 0);
    @(negedge clk);
    rd(A_CTRL, v); check("R3 at 16", {31'd0, v[9]}, 1);
    check("R10 irq high", {31'd0, irq}, 1);
    wr(A_CTRL, RUN | 32'hF);
    rd(A_CTRL, v); check("R11 write 0 keeps flag", {31'd0, v[9]}, 1);
    check("R10 irq gated off", {31'd0, irq}, 0);
    wr(A_CTRL, RUN | LI | 32'hF);
    rd(A_CTRL, v); check("R11 w1c", {31'd0, v[9]}, 0);
    wr(A_CTRL, 0);
    feed();
  endtask

  task automatic t_late_rst();
    logic [31:0] v;
    wr(A_CTRL, RUN | REN | 32'hE0);
    repeat (31) @(negedge clk);
    check("R4 no early pulse", {31'd0, rst_req}, 0);
    @(negedge clk);
    check("R4 pulse", {31'd0, rst_req}, 1);
    rd(A_CTRL, v); check("R4 flag", {31'd0, v[31]}, 1);
    @(negedge clk);
    check("R4 one cycle", {31'd0, rst_req}, 0);
    wr(A_CTRL, LR);
    feed();
    wr(A_CTRL, RUN | 32'hE0);
    repeat (32) @(negedge clk);
    check("R4 disabled no pulse", {31'd0, rst_req}, 0);
    rd(A_CTRL, v); check("R4 flag without enable", {31'd0, v[31]}, 1);
    wr(A_CTRL, LR);
    feed();
  endtask

  task automatic t_key();
    logic [31:0] c, v;
    wr(A_CTRL, RUN);
    repeat (20) @(negedge clk);
    feed();
    rd(A_CNT, v); check("R5 restart", v, 0);
    rd(A_CNT, c);
    wr(A_FEED, 32'h5A);
    rd(A_CNT, v); check("R6 lone second key", v, c + 1);
    rd(A_CNT, c);
    wr(A_FEED, 32'hA5); wr(A_FEED, 32'h33); wr(A_FEED, 32'h5A);
    rd(A_CNT, v); check("R6 broken pair", v, c + 3);
    rd(A_CNT, c);
    wr(A_FEED, 32'hA5); wr(A_FEED, 32'hA5); wr(A_FEED, 32'h5A);
    rd(A_CNT, v); check("R6 double first key", v, c + 3);
    feed();
    rd(A_CNT, v); check("R5 key recovers", v, 0);
    wr(A_CTRL, 0);
    feed();
  endtask

  task automatic t_window();
    logic [31:0] v, cfg;
    cfg = RUN | WIN | REN | IEN | 32'h00E_C0000;
    wr(A_CTRL, cfg);
    repeat (50) @(negedge clk);
    feed();
    rd(A_CTRL, v); check("R7 early int flag", {31'd0, v[12]}, 1);
    check("R8 no early reset at 51", {31'd0, v[30]}, 0);
    check("R8 no pulse at 51", {31'd0, rst_req}, 0);
    check("R10 irq from early flag", {31'd0, irq}, 1);
    wr(A_CTRL, cfg | EI);
    feed();
    rd(A_CTRL, v); check("R8 early reset flag", {31'd0, v[30]}, 1);
    check("R8 pulse", {31'd0, rst_req}, 1);
    wr(A_CTRL, (cfg & ~WIN) | EI | ER);
    feed();
    rd(A_CTRL, v); check("R9 no flags", {30'd0, v[30], v[12]}, 0);
    check("R9 no pulse", {31'd0, rst_req}, 0);
    wr(A_CTRL, 0);
    feed();
  endtask

  task automatic t_collision();
    logic [31:0] v;
    wr(A_CTRL, RUN | IEN | 32'hF);
    repeat (14) @(negedge clk);
    wr(A_FEED, 32'hA5);
    wr(A_FEED, 32'h5A);
    rd(A_CNT, v);  check("R12 count restarted", v, 0);
    rd(A_CTRL, v); check("R12 flag not set", {31'd0, v[9]}, 0);
    repeat (16) @(negedge clk);
    rd(A_CTRL, v); check("R12 flag after full run", {31'd0, v[9]}, 1);
    wr(A_CTRL, LI);
    feed();
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(A_CSEL, 32'h5);
    rd(A_CSEL, v); check("R13 csel", v, 5);
    wr(A_CSEL, 32'hFFFF_FFFF);
    rd(A_CSEL, v); check("R13 csel width", v, 7);
    wr(A_CNT, 32'h12345);
    rd(A_CNT, v); check("R13 count ignores write", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_late_int();
    t_late_rst();
    t_key();
    t_window();
    t_collision();
    t_regs();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule